// File: doc/BRIEF.md
# Quad Wiper Register Bank with Transfer Engine

This block keeps the wiper positions of four potentiometer channels together with four stored presets per channel. A frame receiver upstream decodes each host command and hands it over as one strobe with an opcode, a preset index, a channel index and a data byte. The block then runs the command: it reads or writes a wiper or a preset, copies between a preset and its channel's wiper, moves the same-numbered preset of every channel at once, or steps one wiper up or down by a single position.

Wiper values drive the position outputs after one extra register stage, which stands for the short settling delay of a real wiper. A preset store stands for a slow nonvolatile program cycle. Every command that writes a preset raises a busy flag for a fixed number of clock cycles. While the flag is high, any new command is refused and flagged, and no state changes.

Top module: `wiper_bank_top`

## Requirements
- R1: After reset every wiper register and every position output holds WIPER_INIT (default 0x80), every preset holds 0x00, and busy, rd_valid and cmd_reject are low.
- R2: Opcode 4'b1010 stores cmd_data into the wiper register of channel cmd_pot. The new value reaches that channel's byte of wiper_out (byte p at bits 8p+7:8p) at the second rising edge after the command is accepted.
- R3: Opcode 4'b1001 returns the wiper register of channel cmd_pot on rd_data, with rd_valid high for exactly the one cycle after acceptance.
- R4: Opcode 4'b1100 stores cmd_data into preset cmd_reg of channel cmd_pot. Opcode 4'b1011 returns that preset on rd_data with a one-cycle rd_valid pulse. No other preset changes.
- R5: Opcode 4'b1101 copies preset cmd_reg of channel cmd_pot into that channel's wiper register.
- R6: Opcode 4'b1110 copies the wiper register of channel cmd_pot into its preset cmd_reg.
- R7: Opcode 4'b0001 with cmd_pot equal to 0 copies preset cmd_reg of every channel into that channel's wiper register. With a nonzero cmd_pot the command changes nothing.
- R8: Opcode 4'b1000 with cmd_pot equal to 0 copies every wiper register into preset cmd_reg of the same channel. With a nonzero cmd_pot the command changes nothing and busy stays low.
- R9: An accepted preset-writing command (4'b1100, 4'b1110, or 4'b1000 with cmd_pot 0) holds busy high for exactly NV_BUSY_CYC cycles, starting the cycle after acceptance. No other command raises busy.
- R10: A command presented while busy is high, including in the last busy cycle, is refused. cmd_reject pulses high for one cycle, and neither rd_valid, nor any register, nor the busy timer reacts. A command presented in the first cycle with busy low is accepted.
- R11: The opcodes 4'b0000, 4'b0011 to 4'b0111 and 4'b1111 change no register and raise neither rd_valid, nor cmd_reject, nor busy.
- R12: Opcode 4'b0010 moves the wiper of channel cmd_pot one position up when cmd_data[0] is 1 and one position down when it is 0. The move saturates at 0xFF and at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_reg | input | 2 | Preset index within a channel |
| cmd_pot | input | 2 | Channel index |
| cmd_data | input | 8 | Write data, or step direction in bit 0 |
| rd_data | output | 8 | Read result, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_data |
| busy | output | 1 | Preset program cycle in progress |
| cmd_reject | output | 1 | One-cycle pulse for a command refused while busy |
| wiper_out | output | 32 | Position of each channel, channel p at bits 8p+7:8p |

## Verification
Two things can meet in one cycle: the busy timer's last count and a newly arriving command. The bench issues a preset store and counts off exactly NV_BUSY_CYC-1 more cycles. It then presents a read in the final busy cycle and expects cmd_reject with no read data. It repeats the read one cycle later and expects it to be accepted with the correct value. A second overlap, a wiper write while the previous value is still moving through the output stage, is judged by sampling wiper_out one cycle after the command, when it must still show the old value, and one cycle later, when it must show the new one.

// File: rtl/wb_pkg.sv
package wb_pkg;

    typedef enum logic [3:0] {
        OP_GLB_P2W = 4'b0001,
        OP_STEP    = 4'b0010,
        OP_GLB_W2P = 4'b1000,
        OP_RD_WIP  = 4'b1001,
        OP_WR_WIP  = 4'b1010,
        OP_RD_PRE  = 4'b1011,
        OP_WR_PRE  = 4'b1100,
        OP_CP_P2W  = 4'b1101,
        OP_CP_W2P  = 4'b1110
    } wb_op_e;

    typedef struct packed {
        logic rd_wip;
        logic wr_wip;
        logic rd_pre;
        logic wr_pre;
        logic cp_p2w;
        logic cp_w2p;
        logic glb_p2w;
        logic glb_w2p;
        logic step;
        logic nv_start;
    } wb_ctl_t;

endpackage

// File: rtl/wb_decode.sv
module wb_decode
    import wb_pkg::*;
#(
    parameter int unsigned PSEL_W = 2
) (
    input  logic              accept,
    input  logic [3:0]        op,
    input  logic [PSEL_W-1:0] pot,
    output wb_ctl_t           ctl
);
    logic pot_zero;
    assign pot_zero = (pot == '0);

    always_comb begin
        ctl = '0;
        if (accept) begin
            case (wb_op_e'(op))
                OP_RD_WIP:  ctl.rd_wip  = 1'b1;
                OP_WR_WIP:  ctl.wr_wip  = 1'b1;
                OP_RD_PRE:  ctl.rd_pre  = 1'b1;
                OP_WR_PRE:  ctl.wr_pre  = 1'b1;
                OP_CP_P2W:  ctl.cp_p2w  = 1'b1;
                OP_CP_W2P:  ctl.cp_w2p  = 1'b1;
                OP_GLB_P2W: ctl.glb_p2w = pot_zero;
                OP_GLB_W2P: ctl.glb_w2p = pot_zero;
                OP_STEP:    ctl.step    = 1'b1;
                default:    ctl         = '0;
            endcase
        end
        ctl.nv_start = ctl.wr_pre | ctl.cp_w2p | ctl.glb_w2p;
    end
endmodule

// File: rtl/wb_nv_timer.sv
module wb_nv_timer #(
    parameter int unsigned CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wb_wiper_out.sv
module wb_wiper_out #(
    parameter int unsigned POTS       = 4,
    parameter int unsigned DW         = 8,
    parameter logic [7:0]  WIPER_INIT = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [POTS-1:0][DW-1:0]  wcr,
    output logic [POTS-1:0][DW-1:0]  pos
);
    for (genvar p = 0; p < POTS; p++) begin : g_pot
        logic [DW-1:0] pos_d, pos_q;

        always_comb begin
            pos_d = wcr[p];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pos_q <= DW'(WIPER_INIT);
            end else begin
                pos_q <= pos_d;
            end
        end

        assign pos[p] = pos_q;
    end
endmodule

// File: rtl/wiper_bank_top.sv
module wiper_bank_top
    import wb_pkg::*;
#(
    parameter int unsigned POTS        = 4,
    parameter int unsigned REGS        = 4,
    parameter int unsigned DW          = 8,
    parameter int unsigned NV_BUSY_CYC = 40,
    parameter logic [7:0]  WIPER_INIT  = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [3:0]           cmd_op,
    input  logic [1:0]           cmd_reg,
    input  logic [1:0]           cmd_pot,
    input  logic [7:0]           cmd_data,
    output logic [7:0]           rd_data,
    output logic                 rd_valid,
    output logic                 busy,
    output logic                 cmd_reject,
    output logic [POTS*DW-1:0]   wiper_out
);
    localparam int unsigned PSEL_W = $clog2(POTS);
    localparam int unsigned RSEL_W = $clog2(REGS);

    typedef struct packed {
        logic [POTS-1:0][DW-1:0]            wcr;
        logic [POTS-1:0][REGS-1:0][DW-1:0]  pre;
        logic [DW-1:0]                      rd_data;
        logic                               rd_valid;
        logic                               reject;
    } st_t;

    st_t     s_d, s_q;
    wb_ctl_t ctl;
    logic    accept;
    logic    nv_busy;

    logic [PSEL_W-1:0] psel;
    logic [RSEL_W-1:0] rsel;
    assign psel = PSEL_W'(cmd_pot);
    assign rsel = RSEL_W'(cmd_reg);

    assign accept = cmd_valid & ~nv_busy;

    wb_decode #(.PSEL_W(PSEL_W)) u_dec (
        .accept (accept),
        .op     (cmd_op),
        .pot    (psel),
        .ctl    (ctl)
    );

    wb_nv_timer #(.CYC(NV_BUSY_CYC)) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ctl.nv_start),
        .busy   (nv_busy)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        s_d.reject   = cmd_valid & nv_busy;

        if (ctl.rd_wip) begin
            s_d.rd_data  = s_q.wcr[psel];
            s_d.rd_valid = 1'b1;
        end
        if (ctl.rd_pre) begin
            s_d.rd_data  = s_q.pre[psel][rsel];
            s_d.rd_valid = 1'b1;
        end
        if (ctl.wr_wip) begin
            s_d.wcr[psel] = DW'(cmd_data);
        end
        if (ctl.wr_pre) begin
            s_d.pre[psel][rsel] = DW'(cmd_data);
        end
        if (ctl.cp_p2w) begin
            s_d.wcr[psel] = s_q.pre[psel][rsel];
        end
        if (ctl.cp_w2p) begin
            s_d.pre[psel][rsel] = s_q.wcr[psel];
        end
        for (int p = 0; p < POTS; p++) begin
            if (ctl.glb_p2w) begin
                s_d.wcr[p] = s_q.pre[p][rsel];
            end
            if (ctl.glb_w2p) begin
                s_d.pre[p][rsel] = s_q.wcr[p];
            end
        end
        if (ctl.step) begin
            if (cmd_data[0]) begin
                if (s_q.wcr[psel] != '1) begin
                    s_d.wcr[psel] = s_q.wcr[psel] + 1'b1;
                end
            end else begin
                if (s_q.wcr[psel] != '0) begin
                    s_d.wcr[psel] = s_q.wcr[psel] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int p = 0; p < POTS; p++) begin
                s_q.wcr[p] <= DW'(WIPER_INIT);
            end
        end else begin
            s_q <= s_d;
        end
    end

    logic [POTS-1:0][DW-1:0] pos;

    wb_wiper_out #(.POTS(POTS), .DW(DW), .WIPER_INIT(WIPER_INIT)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wcr    (s_q.wcr),
        .pos    (pos)
    );

    assign wiper_out  = pos;
    assign rd_data    = 8'(s_q.rd_data);
    assign rd_valid   = s_q.rd_valid;
    assign cmd_reject = s_q.reject;
    assign busy       = nv_busy;
endmodule

// File: rtl/wb_checker.sv
module wb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic [1:0] cmd_pot,
    input logic       busy,
    input logic       rd_valid,
    input logic       cmd_reject
);
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (cmd_reject && !rd_valid)); // R10

    AST_REJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> ($past(cmd_valid) && $past(busy))); // R10

    AST_READ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cmd_valid) && !$past(busy)
                      && ($past(cmd_op) == 4'b1001 || $past(cmd_op) == 4'b1011))); // R3

    AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid)
                         && ($past(cmd_op) == 4'b1100 || $past(cmd_op) == 4'b1110
                             || ($past(cmd_op) == 4'b1000 && $past(cmd_pot) == 2'b00)))); // R9

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op inside {4'b0000, 4'b0011, 4'b0100, 4'b0101,
                                               4'b0110, 4'b0111, 4'b1111}))
        |=> (!rd_valid && !cmd_reject && !busy)); // R11
endmodule

bind wiper_bank_top wb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_pot    (cmd_pot),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .cmd_reject (cmd_reject)
);

// File: tb/wiper_bank_top_tb.sv
`timescale 1ns/1ps
module wiper_bank_top_tb;
    localparam int NV = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [1:0] cmd_reg = '0;
    logic [1:0] cmd_pot = '0;
    logic [7:0] cmd_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid, busy, cmd_reject;
    logic [31:0] wiper_out;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wiper_bank_top #(.NV_BUSY_CYC(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .cmd_reject(cmd_reject), .wiper_out(wiper_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wip(input int p);
        return wiper_out[p*8 +: 8];
    endfunction

    // called at a negedge; returns at the next negedge, where registered results show
    task automatic cmd(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                       input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_pot = p; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [3:0] op, input logic [1:0] r,
                      input logic [1:0] p, input logic [7:0] exp);
        cmd(op, r, p, 8'h00);
        chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " rd_data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset();
        for (int p = 0; p < 4; p++) chk("R1 wiper_out", 32'(wip(p)), 32'h80);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 reject", 32'(cmd_reject), 0);
        rd("R1 preset", 4'b1011, 2'd2, 2'd3, 8'h00);
        rd("R1 wcr", 4'b1001, 2'd0, 2'd1, 8'h80);
    endtask

    task automatic t_wiper_rw();
        cmd(4'b1010, 2'd0, 2'd2, 8'h3C);
        chk("R2 output still old", 32'(wip(2)), 32'h80);
        chk("R9 no busy on wiper write", 32'(busy), 0);
        @(negedge clk);
        chk("R2 output updated", 32'(wip(2)), 32'h3C);
        rd("R3", 4'b1001, 2'd0, 2'd2, 8'h3C);
        @(negedge clk);
        chk("R3 rd_valid one cycle", 32'(rd_valid), 0);
    endtask

    task automatic t_preset_rw();
        int cnt = 0;
        cmd(4'b1100, 2'd3, 2'd1, 8'hA5);
        while (busy) begin cnt++; @(negedge clk); end
        chk("R9 busy length", 32'(cnt), 32'(NV));
        rd("R4 written preset", 4'b1011, 2'd3, 2'd1, 8'hA5);
        rd("R4 neighbour preset", 4'b1011, 2'd2, 2'd1, 8'h00);
    endtask

    task automatic t_copy();
        cmd(4'b1101, 2'd3, 2'd1, 8'h00);
        chk("R9 no busy on copy to wiper", 32'(busy), 0);
        rd("R5", 4'b1001, 2'd0, 2'd1, 8'hA5);
        cmd(4'b1010, 2'd0, 2'd0, 8'h11);
        cmd(4'b1110, 2'd2, 2'd0, 8'h00);
        chk("R9 busy on copy to preset", 32'(busy), 1);
        wait_idle();
        rd("R6", 4'b1011, 2'd2, 2'd0, 8'h11);
    endtask

    task automatic t_global();
        for (int p = 0; p < 4; p++) begin
            cmd(4'b1100, 2'd1, 2'(p), 8'(8'h10 + p));
            wait_idle();
        end
        cmd(4'b0001, 2'd1, 2'd1, 8'h00);
        rd("R7 nonzero channel ignored", 4'b1001, 2'd0, 2'd3, 8'h80);
        cmd(4'b0001, 2'd1, 2'd0, 8'h00);
        for (int p = 0; p < 4; p++) rd("R7 global to wiper", 4'b1001, 2'd0, 2'(p), 8'(8'h10 + p));
        for (int p = 0; p < 4; p++) cmd(4'b1010, 2'd0, 2'(p), 8'(8'h20 + p));
        cmd(4'b1000, 2'd0, 2'd2, 8'h00);
        chk("R8 nonzero channel no busy", 32'(busy), 0);
        rd("R8 nonzero channel ignored", 4'b1011, 2'd0, 2'd2, 8'h00);
        cmd(4'b1000, 2'd0, 2'd0, 8'h00);
        chk("R8 global busy", 32'(busy), 1);
        wait_idle();
        for (int p = 0; p < 4; p++) rd("R8 global to preset", 4'b1011, 2'd0, 2'(p), 8'(8'h20 + p));
    endtask

    task automatic t_busy_reject();
        cmd(4'b1100, 2'd0, 2'd3, 8'h77);
        cmd(4'b1010, 2'd0, 2'd3, 8'h55);
        chk("R10 reject write", 32'(cmd_reject), 1);
        for (int i = 2; i < NV; i++) @(negedge clk);
        chk("R10 still busy last cycle", 32'(busy), 1);
        cmd(4'b1001, 2'd0, 2'd3, 8'h00);
        chk("R10 reject in last busy cycle", 32'(cmd_reject), 1);
        chk("R10 no read when refused", 32'(rd_valid), 0);
        chk("R10 busy ended", 32'(busy), 0);
        rd("R10 first idle cycle accepted", 4'b1001, 2'd0, 2'd3, 8'h23);
        chk("R10 no reject when idle", 32'(cmd_reject), 0);
        rd("R4 preset under busy kept", 4'b1011, 2'd0, 2'd3, 8'h77);
    endtask

    task automatic t_undef();
        logic [3:0] ops [7] = '{4'b0000, 4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1111};
        for (int i = 0; i < 7; i++) begin
            cmd(ops[i], 2'd0, 2'd0, 8'hEE);
            chk("R11 no rd_valid", 32'(rd_valid), 0);
            chk("R11 no reject", 32'(cmd_reject), 0);
            chk("R11 no busy", 32'(busy), 0);
        end
        @(negedge clk);
        for (int p = 0; p < 4; p++) chk("R11 wipers unchanged", 32'(wip(p)), 32'(8'h20 + p));
        rd("R11 preset unchanged", 4'b1011, 2'd0, 2'd0, 8'h20);
    endtask

    task automatic t_step();
        cmd(4'b1010, 2'd0, 2'd2, 8'hFE);
        cmd(4'b0010, 2'd0, 2'd2, 8'h01);
        cmd(4'b0010, 2'd0, 2'd2, 8'h01);
        rd("R12 up saturates", 4'b1001, 2'd0, 2'd2, 8'hFF);
        cmd(4'b1010, 2'd0, 2'd2, 8'h01);
        cmd(4'b0010, 2'd0, 2'd2, 8'h00);
        cmd(4'b0010, 2'd0, 2'd2, 8'h00);
        rd("R12 down saturates", 4'b1001, 2'd0, 2'd2, 8'h00);
        cmd(4'b0010, 2'd0, 2'd2, 8'h01);
        @(negedge clk);
        chk("R12 step reaches output", 32'(wip(2)), 32'h01);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wiper_rw();
        t_preset_rw();
        t_copy();
        t_global();
        t_busy_reject();
        t_undef();
        t_step();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule